// File: doc/BRIEF.md
# Power-of-Two Clock Prescaler With Output Gating

This block divides a master clock by a power of two chosen by a 4-bit ratio code. Codes 1 to 8 give a divided clock with a 50% duty cycle. Code 0 hands the master clock straight to the output. Codes 9 to 15 are clamped to the deepest ratio, divide-by-256. The block also decides whether the output runs at all. It combines a wake pin, an output-enable pin and an output-enable configuration bit into one run condition, which passes through a synchronizer.

While the output is stopped, a park-mode bit chooses what the pad does. It can drive the line low, or the drive enable can drop so that the tristate pad releases the line. The block has no data stream, so every pin is a plain level control and there is no valid/ready handshake.

Ratio changes are made glitch-free. A new code is adopted only at the last cycle of a low phase. After that the output stays low for one more low phase of the new ratio. Selecting or leaving the pass-through path is switched on the falling edge of the master clock. When the output is restarted it begins from a cleared counter with a full low phase.

Top module: `pow2_prescale_gate`

## Requirements
- R1: While reset is asserted, and until the run condition has been seen, clk_out is 0 and clk_out_en equals stop_low.
- R2: For an effective ratio code x from 1 to 8, the run condition starts the output. At the second rising edge after the condition is applied, clk_out is low; it then stays low for 2^(x-1) further cycles, followed by 2^(x-1) cycles high, and this low/high pattern repeats.
- R3: For ratio code 0 the output copies the master clock (high in its high phase, low in its low phase), starting from the third rising edge after the run condition is applied.
- R4: ratio_code values 9 to 15 behave exactly like code 8 (divide by 256).
- R5: The run condition is awake_pin = 1 AND (oe_gate_bit = 0 OR oe_pin = 1). It passes through a two-stage synchronizer, so a change shows at the output from the second rising edge on.
- R6: While stopped with stop_low = 0, clk_out_en is 0 and clk_out is 0, so the pad is released to high impedance.
- R7: While stopped with stop_low = 1, clk_out_en is 1 and clk_out is 0, so the pad drives low.
- R8: While the output runs, clk_out_en is 1.
- R9: A changed ratio code is adopted only at the last cycle of a low phase of the current ratio. At that edge the output stays low and the counter clears. The output then holds low for 2^(x_new-1) more cycles before the first high phase of the new ratio. No high phase is ever cut short by the change.
- R10: After a stop, a restart begins with a full low phase of 2^(x-1) cycles, whatever level the output had when it was stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 4 | Requested division exponent; values above 8 are clamped to 8 |
| oe_gate_bit | input | 1 | Configuration bit; at 1, oe_pin must be high for the output to run |
| oe_pin | input | 1 | Output-enable pin |
| awake_pin | input | 1 | Power-state pin; must be high for the output to run |
| stop_low | input | 1 | Park mode while stopped: 1 drives low, 0 releases the pad |
| clk_out | output | 1 | Divided or passed-through clock |
| clk_out_en | output | 1 | Drive enable for the tristate output pad |

## Verification
Two functions can fall on the same rising edge: the counter reaching the last cycle of a low phase, and a new ratio code being presented. The bench provokes this by changing the code while the output is high. It then judges the full low run that follows against the old low length plus the new one, in both directions (2 to 1, then 1 to 3). Stop and restart are also made to land in the middle of a high phase. This checks that the counter clears and that the next low phase is full length.

// File: rtl/p2g_pkg.sv
package p2g_pkg;
  localparam int P2G_CODE_W  = 4;
  localparam int P2G_MAX_X   = 8;
  localparam int P2G_SYNC_ST = 2;
endpackage

// File: rtl/p2g_sync.sv
module p2g_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= (chain << 1) | STAGES'(d);
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/p2g_div_core.sv
module p2g_div_core #(
  parameter int MAX_X = 8,
  localparam int XW   = $clog2(MAX_X + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [XW-1:0] x_req,
  output logic          div_out,
  output logic [XW-1:0] x_cur
);
  logic [MAX_X-1:0] cnt, cnt_nx;
  logic [MAX_X:0]   one_sh, mask_w, half_w, half_m1;
  logic             end_low, nx_bit;

  always_comb begin
    cnt_nx  = cnt + 1'b1;
    one_sh  = (MAX_X + 1)'(1) << x_cur;
    mask_w  = one_sh - 1'b1;
    half_w  = one_sh >> 1;
    half_m1 = half_w - 1'b1;
    // last cycle of a low phase: bit x-1 low, all bits below it high
    end_low = (x_cur == '0) || (({1'b0, cnt} & mask_w) == half_m1);
    nx_bit  = |({1'b0, cnt_nx} & half_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_out <= 1'b0;
      x_cur   <= '0;
    end else if (!run) begin
      cnt     <= '0;
      div_out <= 1'b0;
      x_cur   <= x_req;
    end else if (end_low && (x_req != x_cur)) begin
      cnt     <= '0;
      div_out <= 1'b0;
      x_cur   <= x_req;
    end else begin
      cnt     <= cnt_nx;
      div_out <= nx_bit;
    end
  end
endmodule

// File: rtl/p2g_pass_sel.sv
module p2g_pass_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic x_is0,
  output logic pass
);
  // updated while the master clock is low, so the path swap cannot chop a pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass <= 1'b0;
    else        pass <= run & x_is0;
  end
endmodule

// File: rtl/pow2_prescale_gate.sv
module pow2_prescale_gate
  import p2g_pkg::*;
#(
  parameter int CODE_W      = P2G_CODE_W,
  parameter int MAX_X       = P2G_MAX_X,
  parameter int SYNC_STAGES = P2G_SYNC_ST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              oe_gate_bit,
  input  logic              oe_pin,
  input  logic              awake_pin,
  input  logic              stop_low,
  output logic              clk_out,
  output logic              clk_out_en
);
  localparam int XW = $clog2(MAX_X + 1);

  logic          run_req, run_q, div_out, pass_q;
  logic [XW-1:0] x_req, x_cur;

  assign run_req = awake_pin & (~oe_gate_bit | oe_pin);

  always_comb begin
    if (ratio_code > CODE_W'(MAX_X)) x_req = XW'(MAX_X);
    else                             x_req = XW'(ratio_code);
  end

  p2g_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(run_req), .q(run_q)
  );

  p2g_div_core #(.MAX_X(MAX_X)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_q), .x_req(x_req),
    .div_out(div_out), .x_cur(x_cur)
  );

  p2g_pass_sel u_pass (
    .clk(clk), .rst_n(rst_n), .run(run_q), .x_is0(x_cur == '0), .pass(pass_q)
  );

  assign clk_out    = pass_q ? clk : (div_out & run_q);
  assign clk_out_en = run_q | pass_q | stop_low;
endmodule

// File: rtl/p2g_checker.sv
module p2g_checker #(
  parameter int MAX_X = 8,
  localparam int XW   = $clog2(MAX_X + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_gate_bit,
  input logic          oe_pin,
  input logic          awake_pin,
  input logic          stop_low,
  input logic          clk_out,
  input logic          clk_out_en,
  input logic          run_q,
  input logic          div_out,
  input logic [XW-1:0] x_cur
);
  logic       want;
  logic [2:0] since;

  assign want = awake_pin & (~oe_gate_bit | oe_pin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end

  a_r6_release_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 3'd4 && !$past(want, 2) && !$past(want, 3) && !stop_low) |-> (!clk_out_en && !clk_out));

  a_r7_park_low_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 3'd4 && !$past(want, 2) && !$past(want, 3) && stop_low) |-> (clk_out_en && !clk_out));

  a_r8_drive_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 3'd4 && $past(want, 2) && $past(want, 3)) |-> clk_out_en);

  a_r4_exponent_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    x_cur <= XW'(MAX_X));

  a_r9_switch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 3'd1 && $past(run_q) && (x_cur != $past(x_cur))) |-> !$past(div_out));

  a_r10_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !div_out);
endmodule

bind pow2_prescale_gate p2g_checker #(.MAX_X(MAX_X)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_gate_bit(oe_gate_bit), .oe_pin(oe_pin),
  .awake_pin(awake_pin), .stop_low(stop_low), .clk_out(clk_out),
  .clk_out_en(clk_out_en), .run_q(run_q), .div_out(div_out), .x_cur(x_cur)
);

// File: tb/test_pow2_prescale_gate.sv
`timescale 1ns/1ps
module test_pow2_prescale_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ratio_code = '0;
  logic       oe_gate_bit = 1'b0, oe_pin = 1'b0, awake_pin = 1'b0, stop_low = 1'b0;
  logic       clk_out, clk_out_en;

  typedef struct { bit dc; logic o; logic e; string tag; } exp_t;
  exp_t q[$];
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pow2_prescale_gate i_pow2_prescale_gate (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .oe_gate_bit(oe_gate_bit),
    .oe_pin(oe_pin), .awake_pin(awake_pin), .stop_low(stop_low),
    .clk_out(clk_out), .clk_out_en(clk_out_en)
  );

  // monitor: one expectation per rising edge, sampled 3 ns after it
  initial forever begin
    @(posedge clk);
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (!e.dc) begin
        n_vec++;
        if (clk_out !== e.o || clk_out_en !== e.e) begin
          n_bad++;
          $display("FAIL %s: clk_out/en actual %b/%b expected %b/%b at %0t",
                   e.tag, clk_out, clk_out_en, e.o, e.e, $time);
        end
      end
    end
  end

  // push the expectation for the coming rising edge, then move to the next falling edge
  task automatic cyc(input bit dc, input logic o, input logic e, input string tag);
    exp_t x;
    x.dc = dc; x.o = o; x.e = e; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    #1;
  endtask

  task automatic run_seq(input int code, input bit cfg, input bit pin, input bit pwr,
                         input int n, input string tag);
    int  xe;
    bit  on;
    ratio_code = 4'(code); oe_gate_bit = cfg; oe_pin = pin; awake_pin = pwr;
    xe = (code > 8) ? 8 : code;
    on = pwr && (!cfg || pin);
    cyc(0, 1'b0, stop_low, tag);
    for (int k = 0; k < n; k++) begin
      if (on) begin
        logic b;
        if (xe == 0) b = (k >= 1);
        else         b = 1'((k >> (xe - 1)) & 1);
        cyc(0, b, 1'b1, tag);
        if (xe == 0 && k >= 2) begin
          #2;
          n_vec++;
          if (clk_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R3: low-phase clk_out actual %b expected 0 at %0t", clk_out, $time);
          end
        end
      end else begin
        cyc(0, 1'b0, stop_low, tag);
      end
    end
  endtask

  task automatic stop_seq(input int n, input string tag);
    awake_pin = 1'b0;
    cyc(1, 1'b0, 1'b0, tag);
    cyc(1, 1'b0, 1'b0, tag);
    for (int k = 0; k < n; k++) cyc(0, 1'b0, stop_low, tag);
  endtask

  initial begin
    @(negedge clk);
    #1;
    // R1: reset state in both park modes
    stop_low = 1'b1;
    for (int k = 0; k < 3; k++) cyc(0, 1'b0, 1'b1, "R1");
    stop_low = 1'b0;
    for (int k = 0; k < 2; k++) cyc(0, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) cyc(0, 1'b0, 1'b0, "R1");

    // R2 R8: several ratios, drive on while running; R6 on stop
    run_seq(1, 0, 0, 1, 12, "R2 R8"); stop_seq(4, "R6");
    run_seq(3, 0, 0, 1, 24, "R2 R8"); stop_seq(4, "R6");
    run_seq(0, 0, 0, 1, 10, "R3");   stop_seq(4, "R6");
    run_seq(8, 0, 0, 1, 600, "R2");  stop_seq(4, "R6");
    // R4: clamped codes
    run_seq(13, 0, 0, 1, 600, "R4"); stop_seq(4, "R6");
    run_seq(15, 0, 0, 1, 300, "R4"); stop_seq(4, "R6");

    // R5: run condition combinations
    run_seq(2, 1, 0, 1, 10, "R5");
    run_seq(2, 1, 1, 1, 10, "R5"); stop_seq(4, "R5");
    run_seq(2, 0, 0, 1, 10, "R5"); stop_seq(4, "R5");
    run_seq(2, 0, 1, 0, 10, "R5");

    // R7: park low while stopped, before and after running
    stop_low = 1'b1;
    run_seq(2, 1, 0, 1, 8, "R7");
    run_seq(2, 0, 0, 1, 8, "R7"); stop_seq(6, "R7");
    stop_low = 1'b0;

    // R9: ratio change lands while the output is high
    run_seq(2, 0, 0, 1, 4, "R9");
    ratio_code = 4'd1;
    cyc(0, 0, 1, "R9"); cyc(0, 0, 1, "R9"); cyc(0, 0, 1, "R9"); cyc(0, 1, 1, "R9");
    cyc(0, 0, 1, "R9"); cyc(0, 1, 1, "R9"); cyc(0, 0, 1, "R9"); cyc(0, 1, 1, "R9");
    ratio_code = 4'd3;
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, "R9");
    for (int k = 0; k < 4; k++) cyc(0, 1, 1, "R9");
    cyc(0, 0, 1, "R9");
    stop_seq(4, "R6");

    // R10: stop in a high phase, restart starts with a full low phase
    run_seq(3, 0, 0, 1, 6, "R10"); stop_seq(3, "R10");
    run_seq(3, 0, 0, 1, 12, "R10"); stop_seq(3, "R6");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (all R): actual still running expected finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule